// File: doc/BRIEF.md
# Branch Condition and Set-Less-Than Unit

This combinational unit sits in the execute stage of a processor core. It compares two register operands and drives two results. The first is a set-less-than value for the signed and unsigned compare instructions. The second is a branch-taken flag for the equal, not-equal and compare-against-zero branches.

Every decision comes from one subtraction, formed as A plus the inverse of B plus one. Equality is read from a zero difference. Signed ordering is read from the sign of the difference corrected by the overflow flag. Unsigned ordering is read from the carry out. For the compare-against-zero branches, the right-hand side of the subtractor is forced to zero, so the same adder serves every operation.

Top module: `cond_unit`

## Requirements
- R1: With op code 0 (signed set-less-than), `set_val` is 1 when `opnd_a` is less than `opnd_b` as two's-complement numbers, and 0 otherwise.
- R2: With op code 1 (unsigned set-less-than), `set_val` is 1 when `opnd_a` is less than `opnd_b` as unsigned numbers, and 0 otherwise.
- R3: All bits of `set_val` above bit 0 are zero for every op code and every operand.
- R4: With op code 2 (branch on equal), `take` is 1 exactly when the two operands are identical.
- R5: With op code 3 (branch on not equal), `take` is 1 exactly when the two operands differ.
- R6: With op code 4, `take` is 1 when `opnd_a` is negative. With op code 5, `take` is 1 when `opnd_a` is negative or zero.
- R7: With op code 6, `take` is 1 when `opnd_a` is positive and non-zero. With op code 7, `take` is 1 when `opnd_a` is zero or positive.
- R8: For op codes 4 to 7, the value on `opnd_b` has no effect on `take` or `set_val`.
- R9: Branch op codes (2 to 7) hold `set_val` at 0. Compare op codes (0 and 1) hold `take` at 0.
- R10: Op codes 8 to 15 are undefined and drive both `take` and `set_val` to 0.
- R11: The signed result stays correct when the subtraction overflows. For example, the most negative value compared against 1 gives 1, and the most positive value compared against -1 gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | W | Left-hand operand; the register tested in compare-against-zero branches |
| opnd_b | input | W | Right-hand operand |
| op | input | 4 | Operation select, codes as listed in the requirements |
| take | output | 1 | Branch condition result |
| set_val | output | W | Zero-extended set-less-than result |

## Verification
The bench builds the unit with its default width W = 32. At that width, the sign boundary at 0x8000_0000 and the all-ones pattern can be driven exactly as the compare instructions would see them. Each operand pair is run through all sixteen op codes. This covers the overflow cases of the signed compare, the no-carry case of the unsigned compare, and the undefined codes. The compare-against-zero codes are repeated with different values on `opnd_b`, to show that this operand is ignored.

// File: rtl/cond_unit.sv
module cond_unit #(
  parameter int W = 32
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [3:0]   op,
  output logic         take,
  output logic [W-1:0] set_val
);
  localparam logic [3:0] OP_SLT  = 4'd0;
  localparam logic [3:0] OP_SLTU = 4'd1;
  localparam logic [3:0] OP_EQ   = 4'd2;
  localparam logic [3:0] OP_NE   = 4'd3;
  localparam logic [3:0] OP_LTZ  = 4'd4;
  localparam logic [3:0] OP_LEZ  = 4'd5;
  localparam logic [3:0] OP_GTZ  = 4'd6;
  localparam logic [3:0] OP_GEZ  = 4'd7;

  logic         vs_zero;
  logic [W-1:0] rhs;
  logic [W-1:0] diff;
  logic         carry;
  logic         ovf;
  logic         is_zero;
  logic         lt_s;
  logic         lt_u;

  // compare-against-zero codes share the subtractor with a zero right-hand side
  assign vs_zero      = (op[3:2] == 2'b01);
  assign rhs          = vs_zero ? '0 : opnd_b;
  assign {carry, diff} = {1'b0, opnd_a} + {1'b0, ~rhs} + {{W{1'b0}}, 1'b1};
  assign ovf          = (opnd_a[W-1] ^ rhs[W-1]) & (diff[W-1] ^ opnd_a[W-1]);
  assign is_zero      = ~|diff;
  assign lt_s         = diff[W-1] ^ ovf;
  assign lt_u         = ~carry;

  always_comb begin
    take    = 1'b0;
    set_val = '0;
    case (op)
      OP_SLT:  set_val[0] = lt_s;
      OP_SLTU: set_val[0] = lt_u;
      OP_EQ:   take = is_zero;
      OP_NE:   take = ~is_zero;
      OP_LTZ:  take = lt_s;
      OP_LEZ:  take = lt_s | is_zero;
      OP_GTZ:  take = ~(lt_s | is_zero);
      OP_GEZ:  take = ~lt_s;
      default: begin
        take    = 1'b0;
        set_val = '0;
      end
    endcase
  end
endmodule

// File: rtl/cond_unit_chk.sv
module cond_unit_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [3:0]   op,
  input logic         take,
  input logic [W-1:0] set_val
);
  logic known;
  assign known = !$isunknown({opnd_a, opnd_b, op});

  always_comb begin
    if (known) begin
      assert_upper_clear_R3: assert (set_val[W-1:1] == '0)
        else $error("upper set bits not zero");
      if (op == 4'd0)
        assert_signed_lt_R1: assert (set_val[0] == ($signed(opnd_a) < $signed(opnd_b)))
          else $error("signed compare wrong");
      if (op == 4'd1)
        assert_unsigned_lt_R2: assert (set_val[0] == (opnd_a < opnd_b))
          else $error("unsigned compare wrong");
      if (op == 4'd2)
        assert_equal_R4: assert (take == (opnd_a == opnd_b))
          else $error("equal branch wrong");
      if (op == 4'd3)
        assert_not_equal_R5: assert (take == (opnd_a != opnd_b))
          else $error("not-equal branch wrong");
      if (op == 4'd4)
        assert_ltz_R6: assert (take == opnd_a[W-1])
          else $error("ltz branch wrong");
      if (op == 4'd5)
        assert_lez_R6: assert (take == (opnd_a[W-1] || opnd_a == '0))
          else $error("lez branch wrong");
      if (op == 4'd6)
        assert_gtz_R7: assert (take == (!opnd_a[W-1] && opnd_a != '0))
          else $error("gtz branch wrong");
      if (op == 4'd7)
        assert_gez_R7: assert (take == !opnd_a[W-1])
          else $error("gez branch wrong");
      if (op inside {[4'd2:4'd7]})
        assert_branch_no_set_R9: assert (set_val == '0)
          else $error("branch op drove set value");
      if (op inside {4'd0, 4'd1})
        assert_compare_no_take_R9: assert (!take)
          else $error("compare op drove take");
      if (op[3])
        assert_undefined_quiet_R10: assert (!take && set_val == '0)
          else $error("undefined op not quiet");
    end
  end
endmodule

bind cond_unit cond_unit_chk #(.W(W)) u_chk (
  .opnd_a(opnd_a), .opnd_b(opnd_b), .op(op), .take(take), .set_val(set_val)
);

// File: tb/sim_cond_unit.sv
module sim_cond_unit;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [3:0]   op;
    logic         exp_take;
    logic [W-1:0] exp_set;
    string        tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic [3:0]   op = 4'd0;
  logic         take;
  logic [W-1:0] set_val;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_unit #(.W(W)) u0 (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .op(op), .take(take), .set_val(set_val)
  );

  function automatic string op_tag(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R4";
      4'd3: return "R5";
      4'd4, 4'd5: return "R6";
      4'd6, 4'd7: return "R7";
      default: return "R10";
    endcase
  endfunction

  function automatic item_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input logic [3:0] o, input string tag);
    item_t it;
    it.a = a; it.b = b; it.op = o; it.tag = tag;
    it.exp_take = 1'b0;
    it.exp_set = '0;
    case (o)
      4'd0: it.exp_set = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      4'd1: it.exp_set = {{(W-1){1'b0}}, (a < b)};
      4'd2: it.exp_take = (a == b);
      4'd3: it.exp_take = (a != b);
      4'd4: it.exp_take = ($signed(a) < 0);
      4'd5: it.exp_take = ($signed(a) <= 0);
      4'd6: it.exp_take = ($signed(a) > 0);
      4'd7: it.exp_take = ($signed(a) >= 0);
      default: ;
    endcase
    return it;
  endfunction

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [3:0] o, input string tag);
    @(posedge clk);
    #1;
    opnd_a = a; opnd_b = b; op = o;
    sb.push_back(model(a, b, o, tag));
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_run++;
      if (take !== it.exp_take || set_val !== it.exp_set) begin
        n_fail++;
        $display("FAIL %s op=%0d a=%h b=%h: take=%b set=%h expected take=%b set=%h",
                 it.tag, it.op, it.a, it.b, take, set_val, it.exp_take, it.exp_set);
      end
      n_run++;
      if (set_val[W-1:1] !== '0) begin
        n_fail++;
        $display("FAIL R3 op=%0d: set=%h expected upper bits 0", it.op, set_val);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run=%0d expected completion", n_run);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  localparam int NP = 12;
  logic [W-1:0] va [NP];
  logic [W-1:0] vb [NP];

  initial begin
    va[0] = 32'h0;        vb[0] = 32'h0;
    va[1] = 32'h5;        vb[1] = 32'h9;
    va[2] = 32'h9;        vb[2] = 32'h5;
    va[3] = 32'hFFFF_FFFF; vb[3] = 32'h1;
    va[4] = 32'h1;        vb[4] = 32'hFFFF_FFFF;
    va[5] = 32'h8000_0000; vb[5] = 32'h1;
    va[6] = 32'h7FFF_FFFF; vb[6] = 32'hFFFF_FFFF;
    va[7] = 32'h8000_0000; vb[7] = 32'h7FFF_FFFF;
    va[8] = 32'h1234_5678; vb[8] = 32'h1234_5678;
    va[9] = 32'h8000_0000; vb[9] = 32'h8000_0000;
    va[10] = 32'hFFFF_FFFE; vb[10] = 32'hFFFF_FFFF;
    va[11] = 32'h0;       vb[11] = 32'h8000_0000;

    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle values after reset: zero operands, signed compare
    drive('0, '0, 4'd0, "R1 reset");

    for (int p = 0; p < NP; p++)
      for (int o = 0; o < 16; o++)
        drive(va[p], vb[p], 4'(o), op_tag(4'(o)));

    // R11: subtraction overflow corners of the signed compare
    drive(32'h8000_0000, 32'h1, 4'd0, "R11");
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'd0, "R11");
    drive(32'h7FFF_FFFF, 32'h8000_0000, 4'd0, "R11");
    drive(32'h8000_0000, 32'h7FFF_FFFF, 4'd0, "R11");

    // R8: opnd_b varied under the zero-compare codes
    for (int o = 4; o < 8; o++) begin
      drive(32'h0, 32'h8000_0000, 4'(o), "R8");
      drive(32'h0, 32'h7FFF_FFFF, 4'(o), "R8");
      drive(32'h3, 32'h0000_0007, 4'(o), "R8");
      drive(32'hFFFF_FFFD, 32'hFFFF_FFFC, 4'(o), "R8");
    end

    // R9: branch and compare codes keep the other output quiet
    drive(32'h4, 32'h4, 4'd2, "R9");
    drive(32'h1, 32'h2, 4'd0, "R9");
    drive(32'h1, 32'h2, 4'd1, "R9");

    // R10: undefined codes with operands that would set either output
    drive(32'h1, 32'h2, 4'd8, "R10");
    drive(32'h1, 32'h1, 4'd15, "R10");

    while (sb.size() > 0) @(posedge clk);
    @(posedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule